// File: doc/BRIEF.md
# Asynchronous serial transceiver with selectable framing and self-test loopback

The block serialises bytes onto a transmit line and recovers bytes from a receive line. Both directions use one frame layout: a low start bit, then 5 to 8 data bits least-significant first, then a high stop period. The line rests high. A host-supplied baud tick runs at sixteen times the bit rate. A character-length select and a stop-length select configure the frame. The parallel side has a load/ready handshake for transmit. On the receive side it has a one-clock valid strobe with a framing-error flag.

A self-test switch turns the block back on itself. The receiver listens to the transmit stream. The external receive pin is ignored, and the transmit pin rests high. The four modem status inputs are then fed from the four modem control requests rather than from the pins. With the switch off, every pin connects normally.

The transmitter FSM has four states. TX_IDLE moves to TX_START on an accepted load. TX_START moves to TX_DATA after 16 ticks. TX_DATA moves to TX_STOP after the last data bit. TX_STOP moves to TX_IDLE after the stop length.

The receiver FSM also has four states. RX_IDLE moves to RX_START on a tick that sees the line low. RX_START moves to RX_DATA if the line is still low 8 ticks later, and otherwise falls back to RX_IDLE as a glitch. RX_DATA moves to RX_STOP after the last data bit. RX_STOP moves to RX_IDLE at the first stop-bit centre, where it raises the strobe.

Top module: `uart_lb_core`

## Requirements
- R1: `char_len` 00/01/10/11 selects 5/6/7/8 data bits. A transmitted frame is one low start bit of 16 ticks, then the data bits LSB first at 16 ticks each, then the stop period. The idle level is 1.
- R2: With `stop_long` = 0, the stop period is 16 ticks.
- R3: With `stop_long` = 1, the stop period is 24 ticks for 5-bit characters and 32 ticks for 6-, 7- and 8-bit characters.
- R4: `tx_ready` is 1 exactly while the transmitter is idle. A `tx_load` while it is 0 has no effect. Data, length and stop settings are captured when the load is accepted, and the line goes low in the next cycle.
- R5: The receiver confirms the start bit 8 ticks after first seeing the line low, then samples every later bit 16 ticks apart. `rx_valid` pulses for one clock per character. `rx_byte` holds the character right-justified with zeros above it.
- R6: `rx_frame_err` (valid with `rx_valid`) is 1 when the first stop bit is sampled low. Only that first stop bit is examined, whatever `stop_long` is.
- R7: With `loop_en` = 1, the receiver takes the transmit stream, `ser_rx` is ignored and `ser_tx` is 1.
- R8: `mdm_ctl_out` always equals `mdm_ctl_req`. Bit i of `mdm_stat` comes from `mdm_ctl_req` bit i when `loop_en` = 1 and from `mdm_pin_in` bit i otherwise. Bit 0 pairs DTR with DSR, bit 1 RTS with CTS, bit 2 OUT1 with RI, and bit 3 OUT2 with DCD.
- R9: After reset, `tx_ready` = 1, `ser_tx` = 1 and `rx_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-clock pulse at 16x bit rate |
| char_len | input | 2 | Data bits select (5 + value) |
| stop_long | input | 1 | Long stop period select |
| loop_en | input | 1 | Self-test loopback enable |
| tx_byte | input | 8 | Byte to transmit |
| tx_load | input | 1 | Load request for `tx_byte` |
| tx_ready | output | 1 | Transmitter idle |
| rx_byte | output | 8 | Last received character |
| rx_valid | output | 1 | One-clock receive strobe |
| rx_frame_err | output | 1 | First stop bit was low |
| ser_tx | output | 1 | Serial transmit pin |
| ser_rx | input | 1 | Serial receive pin |
| mdm_ctl_req | input | 4 | Modem control requests (DTR, RTS, OUT1, OUT2) |
| mdm_ctl_out | output | 4 | Modem control pins |
| mdm_pin_in | input | 4 | Modem status pins (DSR, CTS, RI, DCD) |
| mdm_stat | output | 4 | Modem status seen by the host |

## Verification
The assertions assume that `baud_tick` is a single-cycle pulse with several clocks between pulses. They also assume that the character length and stop select are steady while the receiver is inside a frame, and that `ser_rx` changes only on tick boundaries and holds each level for 16 ticks. The stimulus meets these assumptions. A divider makes the tick every fourth clock. Serial input is driven by a task that counts ticks before each level change. The format and loopback settings are changed only while both directions are idle, apart from one deliberate format change in the middle of a transmit frame, which checks the capture of the settings at load.

// File: rtl/uart_lb_pkg.sv
package uart_lb_pkg;

    typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_e;
    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

    // length select 0..3 maps to 5..8 data bits
    function automatic logic [3:0] char_bits(input logic [1:0] sel);
        return 4'd5 + {2'b00, sel};
    endfunction

endpackage

// File: rtl/uart_lb_tx.sv
module uart_lb_tx
    import uart_lb_pkg::*;
#(
    parameter int OVS = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [1:0]    len_sel,
    input  logic          stop_sel,
    input  logic          load,
    input  logic [DW-1:0] data,
    output logic          ready,
    output logic          line
);
    localparam int CW = $clog2(2 * OVS);
    localparam int BW = $clog2(DW + 1);

    tx_state_e      state_q;
    logic [CW-1:0]  cnt_q;
    logic [CW-1:0]  stop_last_q;
    logic [BW-1:0]  bit_q;
    logic [BW-1:0]  nbits_q;
    logic [DW-1:0]  sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= TX_IDLE;
            cnt_q       <= '0;
            stop_last_q <= '0;
            bit_q       <= '0;
            nbits_q     <= '0;
            sh_q        <= '0;
        end else begin
            unique case (state_q)
                TX_IDLE: begin
                    if (load) begin
                        state_q <= TX_START;
                        cnt_q   <= '0;
                        sh_q    <= data;
                        nbits_q <= BW'(char_bits(len_sel));
                        if (!stop_sel)
                            stop_last_q <= CW'(OVS - 1);
                        else if (len_sel == 2'b00)
                            stop_last_q <= CW'(OVS + OVS / 2 - 1);
                        else
                            stop_last_q <= CW'(2 * OVS - 1);
                    end
                end
                TX_START: begin
                    if (tick) begin
                        if (cnt_q == CW'(OVS - 1)) begin
                            state_q <= TX_DATA;
                            cnt_q   <= '0;
                            bit_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + CW'(1);
                        end
                    end
                end
                TX_DATA: begin
                    if (tick) begin
                        if (cnt_q == CW'(OVS - 1)) begin
                            cnt_q <= '0;
                            sh_q  <= sh_q >> 1;
                            if (bit_q == nbits_q - BW'(1))
                                state_q <= TX_STOP;
                            else
                                bit_q <= bit_q + BW'(1);
                        end else begin
                            cnt_q <= cnt_q + CW'(1);
                        end
                    end
                end
                TX_STOP: begin
                    if (tick) begin
                        if (cnt_q == stop_last_q)
                            state_q <= TX_IDLE;
                        else
                            cnt_q <= cnt_q + CW'(1);
                    end
                end
                default: state_q <= TX_IDLE;
            endcase
        end
    end

    always_comb begin
        ready = (state_q == TX_IDLE);
        unique case (state_q)
            TX_START: line = 1'b0;
            TX_DATA:  line = sh_q[0];
            default:  line = 1'b1;
        endcase
    end

    // R4: an accepted load leaves idle and drives the start level next cycle
    a_r4_accept_start: assert property (@(posedge clk) disable iff (!rst_n)
        ready && load |=> !ready && !line);
    // R1: the line rests high whenever the transmitter is idle
    a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> line);

endmodule

// File: rtl/uart_lb_rx.sv
module uart_lb_rx
    import uart_lb_pkg::*;
#(
    parameter int OVS = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [1:0]    len_sel,
    input  logic          line,
    output logic [DW-1:0] data,
    output logic          valid,
    output logic          ferr
);
    localparam int CNW = $clog2(OVS);
    localparam int BW  = $clog2(DW + 1);

    rx_state_e      state_q;
    logic           line_q;
    logic [CNW-1:0] cnt_q;
    logic [BW-1:0]  bit_q;
    logic [BW-1:0]  nbits_q;
    logic [DW-1:0]  sh_q;
    logic [DW-1:0]  data_q;
    logic           valid_q;
    logic           ferr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            line_q  <= 1'b1;
            cnt_q   <= '0;
            bit_q   <= '0;
            nbits_q <= '0;
            sh_q    <= '0;
            data_q  <= '0;
            valid_q <= 1'b0;
            ferr_q  <= 1'b0;
        end else begin
            line_q  <= line;
            valid_q <= 1'b0;
            unique case (state_q)
                RX_IDLE: begin
                    if (tick && !line_q) begin
                        state_q <= RX_START;
                        cnt_q   <= '0;
                        nbits_q <= BW'(char_bits(len_sel));
                    end
                end
                RX_START: begin
                    if (tick) begin
                        if (cnt_q == CNW'(OVS / 2 - 1)) begin
                            cnt_q <= '0;
                            bit_q <= '0;
                            state_q <= line_q ? RX_IDLE : RX_DATA;
                        end else begin
                            cnt_q <= cnt_q + CNW'(1);
                        end
                    end
                end
                RX_DATA: begin
                    if (tick) begin
                        if (cnt_q == CNW'(OVS - 1)) begin
                            cnt_q <= '0;
                            sh_q  <= {line_q, sh_q[DW-1:1]};
                            if (bit_q == nbits_q - BW'(1))
                                state_q <= RX_STOP;
                            else
                                bit_q <= bit_q + BW'(1);
                        end else begin
                            cnt_q <= cnt_q + CNW'(1);
                        end
                    end
                end
                RX_STOP: begin
                    if (tick) begin
                        if (cnt_q == CNW'(OVS - 1)) begin
                            valid_q <= 1'b1;
                            ferr_q  <= !line_q;
                            data_q  <= sh_q >> (BW'(DW) - nbits_q);
                            state_q <= RX_IDLE;
                        end else begin
                            cnt_q <= cnt_q + CNW'(1);
                        end
                    end
                end
                default: state_q <= RX_IDLE;
            endcase
        end
    end

    always_comb begin
        data  = data_q;
        valid = valid_q;
        ferr  = ferr_q;
    end

    // R5: strobe lasts one clock
    a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);
    // R5: bits above the character length read as zero
    a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> ((data >> nbits_q) == '0));

endmodule

// File: rtl/uart_lb_route.sv
module uart_lb_route #(
    parameter int NMDM = 4
) (
    input  logic            loop_en,
    input  logic            tx_line,
    input  logic            rx_pin,
    input  logic [NMDM-1:0] ctl_req,
    input  logic [NMDM-1:0] stat_pin,
    output logic            tx_pin,
    output logic            rx_line,
    output logic [NMDM-1:0] ctl_pin,
    output logic [NMDM-1:0] stat
);
    always_comb begin
        tx_pin  = loop_en ? 1'b1 : tx_line;
        rx_line = loop_en ? tx_line : rx_pin;
        ctl_pin = ctl_req;
    end

    for (genvar i = 0; i < NMDM; i++) begin : g_stat
        assign stat[i] = loop_en ? ctl_req[i] : stat_pin[i];
    end

endmodule

// File: rtl/uart_lb_core.sv
module uart_lb_core #(
    parameter int OVS  = 16,
    parameter int DW   = 8,
    parameter int NMDM = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            baud_tick,
    input  logic [1:0]      char_len,
    input  logic            stop_long,
    input  logic            loop_en,
    input  logic [DW-1:0]   tx_byte,
    input  logic            tx_load,
    output logic            tx_ready,
    output logic [DW-1:0]   rx_byte,
    output logic            rx_valid,
    output logic            rx_frame_err,
    output logic            ser_tx,
    input  logic            ser_rx,
    input  logic [NMDM-1:0] mdm_ctl_req,
    output logic [NMDM-1:0] mdm_ctl_out,
    input  logic [NMDM-1:0] mdm_pin_in,
    output logic [NMDM-1:0] mdm_stat
);
    logic tx_line;
    logic rx_line;

    uart_lb_tx #(.OVS(OVS), .DW(DW)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .len_sel(char_len),
        .stop_sel(stop_long), .load(tx_load), .data(tx_byte),
        .ready(tx_ready), .line(tx_line)
    );

    uart_lb_rx #(.OVS(OVS), .DW(DW)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .len_sel(char_len),
        .line(rx_line), .data(rx_byte), .valid(rx_valid), .ferr(rx_frame_err)
    );

    uart_lb_route #(.NMDM(NMDM)) u_route (
        .loop_en(loop_en), .tx_line(tx_line), .rx_pin(ser_rx),
        .ctl_req(mdm_ctl_req), .stat_pin(mdm_pin_in),
        .tx_pin(ser_tx), .rx_line(rx_line),
        .ctl_pin(mdm_ctl_out), .stat(mdm_stat)
    );

    // R7: transmit pin rests high during self-test
    a_r7_pin_idle: assert property (@(posedge clk) disable iff (!rst_n)
        loop_en |-> ser_tx);
    // R8: status follows the control requests during self-test
    a_r8_loop_stat: assert property (@(posedge clk) disable iff (!rst_n)
        loop_en |-> (mdm_stat == mdm_ctl_req));
    // R8: status follows the pins otherwise
    a_r8_pin_stat: assert property (@(posedge clk) disable iff (!rst_n)
        !loop_en |-> (mdm_stat == mdm_pin_in));

endmodule

// File: tb/sim_uart_lb_core.sv
`timescale 1ns/1ps
module sim_uart_lb_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic [1:0] char_len = 2'b11;
    logic       stop_long = 1'b0;
    logic       loop_en = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       tx_load = 1'b0;
    logic       tx_ready;
    logic [7:0] rx_byte;
    logic       rx_valid;
    logic       rx_frame_err;
    logic       ser_tx;
    logic       ser_rx = 1'b1;
    logic [3:0] mdm_ctl_req = 4'h0;
    logic [3:0] mdm_ctl_out;
    logic [3:0] mdm_pin_in = 4'h0;
    logic [3:0] mdm_stat;

    int checks = 0;
    int failures = 0;
    int tdiv = 0;
    int txq[$];
    int rxq[$];
    bit prev_valid = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    uart_lb_core u0 (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .char_len(char_len),
        .stop_long(stop_long), .loop_en(loop_en), .tx_byte(tx_byte),
        .tx_load(tx_load), .tx_ready(tx_ready), .rx_byte(rx_byte),
        .rx_valid(rx_valid), .rx_frame_err(rx_frame_err), .ser_tx(ser_tx),
        .ser_rx(ser_rx), .mdm_ctl_req(mdm_ctl_req), .mdm_ctl_out(mdm_ctl_out),
        .mdm_pin_in(mdm_pin_in), .mdm_stat(mdm_stat)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // tick every fourth clock
    always @(negedge clk) begin
        tdiv <= (tdiv + 1) % 4;
        baud_tick <= rst_n && (tdiv == 3);
    end

    // reference model, evaluated with the inputs the design sampled at the last edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (txq.size() == 0 && tx_load) begin
                int nb;
                int stp;
                nb = 5 + char_len;
                stp = !stop_long ? 16 : (char_len == 2'b00 ? 24 : 32);
                for (int k = 0; k < 16; k++) txq.push_back(0);
                for (int b = 0; b < nb; b++)
                    for (int k = 0; k < 16; k++) txq.push_back(tx_byte[b]);
                for (int k = 0; k < stp; k++) txq.push_back(1);
                if (loop_en) rxq.push_back(int'(tx_byte) & ((1 << nb) - 1));
            end else if (baud_tick && txq.size() > 0) begin
                void'(txq.pop_front());
            end
            begin
                int el;
                el = (txq.size() > 0) ? txq[0] : 1;
                chk(tx_ready == (txq.size() == 0), "R4 ready", tx_ready, txq.size() == 0);
                chk(ser_tx == (loop_en ? 1 : el), "R1/R2/R3/R7 tx pin", ser_tx, loop_en ? 1 : el);
                chk(mdm_ctl_out == mdm_ctl_req, "R8 ctl pins", mdm_ctl_out, mdm_ctl_req);
                chk(mdm_stat == (loop_en ? mdm_ctl_req : mdm_pin_in), "R8 status",
                    mdm_stat, loop_en ? mdm_ctl_req : mdm_pin_in);
            end
            if (rx_valid) begin
                chk(!prev_valid, "R5 strobe width", prev_valid, 0);
                if (rxq.size() == 0) begin
                    chk(1'b0, "R5/R7 unexpected character", rx_byte, 0);
                end else begin
                    int e;
                    e = rxq.pop_front();
                    chk(rx_byte == e[7:0], "R5 rx data", rx_byte, e[7:0]);
                    chk(rx_frame_err == e[8], "R6 framing flag", rx_frame_err, e[8]);
                end
            end
            prev_valid = rx_valid;
        end
    end

    task automatic wait_ticks(input int n);
        int k = 0;
        while (k < n) begin
            @(posedge clk);
            if (baud_tick) k++;
        end
        @(negedge clk);
        #1;
    endtask

    task automatic load_tx(input logic [7:0] d);
        @(negedge clk); #1;
        tx_byte = d;
        tx_load = 1'b1;
        @(negedge clk); #1;
        tx_load = 1'b0;
    endtask

    task automatic wait_ready();
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        #1;
    endtask

    task automatic send_ext(input logic [7:0] d, input logic stopv);
        int nb;
        nb = 5 + char_len;
        rxq.push_back({!stopv, 8'(int'(d) & ((1 << nb) - 1))});
        ser_rx = 1'b0;
        wait_ticks(16);
        for (int b = 0; b < nb; b++) begin
            ser_rx = d[b];
            wait_ticks(16);
        end
        ser_rx = stopv;
        wait_ticks(16);
        ser_rx = 1'b1;
        wait_ticks(32);
    endtask

    task automatic finish_up();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_up();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        chk(tx_ready == 1'b1, "R9 ready", tx_ready, 1);
        chk(ser_tx == 1'b1, "R9 tx pin", ser_tx, 1);
        chk(rx_valid == 1'b0, "R9 strobe", rx_valid, 0);
        #1 rst_n = 1'b1;
        repeat (4) @(negedge clk);
        #1;

        // R1/R2: 8 bits, short stop; R4: busy load ignored, format captured at load
        char_len = 2'b11; stop_long = 1'b0;
        load_tx(8'hA5);
        wait_ticks(20);
        char_len = 2'b00;
        load_tx(8'h3C);
        wait_ready();
        // R3: 5 bits with long stop gives 24 ticks
        char_len = 2'b00; stop_long = 1'b1;
        load_tx(8'h16);
        wait_ready();
        // R3: 6 bits with long stop gives 32 ticks
        char_len = 2'b01;
        load_tx(8'hE9);
        wait_ready();
        char_len = 2'b10; stop_long = 1'b0;
        load_tx(8'h5B);
        wait_ready();

        // R5/R6: external receive
        char_len = 2'b11;
        send_ext(8'h3C, 1'b1);
        char_len = 2'b00;
        send_ext(8'hF3, 1'b1);
        char_len = 2'b10;
        send_ext(8'h4D, 1'b0);
        char_len = 2'b01;
        send_ext(8'hAA, 1'b1);

        // R7/R8: self-test loopback
        mdm_ctl_req = 4'b1010; mdm_pin_in = 4'b0101;
        @(negedge clk); #1;
        loop_en = 1'b1;
        ser_rx = 1'b0;
        mdm_ctl_req = 4'b0110;
        char_len = 2'b01; stop_long = 1'b1;
        load_tx(8'hC7);
        wait_ready();
        char_len = 2'b11;
        load_tx(8'h96);
        wait_ready();
        char_len = 2'b00;
        load_tx(8'hFF);
        wait_ready();
        wait_ticks(20);
        mdm_ctl_req = 4'b1001;
        @(negedge clk); #1;
        ser_rx = 1'b1;
        wait_ticks(8);
        loop_en = 1'b0;
        mdm_pin_in = 4'b1110;
        wait_ticks(8);

        // R5/R7: every expected character was delivered
        chk(rxq.size() == 0, "R5/R7 characters pending", rxq.size(), 0);
        finish_up();
    end
endmodule